// File: doc/BRIEF.md
# Toroidal Life Generation Engine

This block stores a two-dimensional field of one-bit cells and produces successive generations of Conway's Life. A generation is worked out one row per clock into a shadow copy of the field. The shadow copy then replaces the visible field in a single cycle. A display scanner reads cells through a registered read port. An editor changes single cells through a write port. A whole-field random fill can be started by a rising edge on its command input.

There are two ways to advance the field. In free-running mode, a new generation is requested every (divisor+1) frame-start pulses. Raising the hold input stops this pacing. A rising edge on the step input always requests exactly one generation. Requests that arrive while the engine is busy are held, one of each kind. The random fill is served before a pending generation.

Top module: `life_engine`

## Requirements
- R1: After synchronous reset every cell is dead, `rd_val` is 0 and the engine is idle.
- R2: In a new generation a cell is alive when it had exactly 3 live neighbours, or when it was alive with exactly 2 live neighbours. Every other cell is dead.
- R3: Neighbours wrap around both edges. Column COLS-1 is adjacent to column 0, and row ROWS-1 is adjacent to row 0.
- R4: While a generation or fill is being computed, reads return the previous field. The whole new field becomes visible in one cycle.
- R5: With `hold` low, a generation is requested on every (`rate_div`+1)-th `frame_pulse`. The pulse counter is cleared while `hold` is high.
- R6: While `hold` is high, `frame_pulse` requests no generation.
- R7: A rising edge of `step_req` requests exactly one generation. Keeping `step_req` high requests no further generations.
- R8: A rising edge of `rand_req` refills the field from a 16-bit LFSR. The LFSR is seeded with 0xACE1 at reset and keeps its state between fills. Each step shifts left and puts the feedback bit into bit 0. The feedback bit is the XOR of bits 15, 13, 12 and 10. Rows are filled in order 0 to ROWS-1, and column c of a row takes the (c+1)-th feedback bit produced for that row.
- R9: An idle write (`wr_en`=1) stores `wr_val` at (`wr_x`,`wr_y`).
- R10: A write made while the engine is busy is held and applied on top of the committed field. It overrides the computed value for that cell, and the latest such write wins.
- R11: `rd_val` is the cell at (`rd_x`,`rd_y`) as it was one clock earlier.
- R12: A step or fill request that arrives while busy is queued and served afterwards. When both are pending, the fill runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle frame-start strobe |
| rate_div | input | DIV_W | Free-run divisor; period is value+1 frames |
| hold | input | 1 | Stops free-run pacing |
| step_req | input | 1 | Single-step request, rising-edge active |
| rand_req | input | 1 | Random fill request, rising-edge active |
| wr_en | input | 1 | Cell write strobe |
| wr_x | input | $clog2(COLS) | Write column |
| wr_y | input | $clog2(ROWS) | Write row |
| wr_val | input | 1 | Value written |
| rd_x | input | $clog2(COLS) | Read column |
| rd_y | input | $clog2(ROWS) | Read row |
| rd_val | output | 1 | Registered cell state |

## Verification
The bench places a blinker across the corner of the field. If the wrap logic were missing, that blinker would decay instead of oscillating. It samples the field in the middle of a computation to catch a design that commits rows one at a time. A step level is held high across several generation times, which would expose level-triggered stepping as repeated generations. Edits and second step requests are also issued in the middle of a computation, and a design that dropped them would show a lost cell or only one generation. Each random fill is compared bit for bit against an independent LFSR model, so a wrong tap, seed or fill order shows up at once.

// File: rtl/life_pkg.sv
package life_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_FILL   = 2'd2,
    ST_COMMIT = 2'd3
  } eng_state_e;

  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/life_pacer.sv
// Turns frame pulses and step edges into generation requests.
module life_pacer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic             hold,
  input  logic             step_req,
  input  logic [DIV_W-1:0] rate_div,
  output logic             gen_req
);
  logic [DIV_W-1:0] fcnt;
  logic             step_q;
  logic             tick;
  logic             step_rise;

  assign step_rise = step_req & ~step_q;
  assign tick      = frame_pulse & ~hold & (fcnt >= rate_div);
  assign gen_req   = tick | step_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= step_req;
      if (hold)
        fcnt <= '0;
      else if (frame_pulse)
        fcnt <= tick ? '0 : fcnt + 1'b1;
    end
  end
endmodule

// File: rtl/life_lfsr_fill.sv
// Unrolled LFSR: one feedback bit per column of a row.
module life_lfsr_fill
  import life_pkg::*;
#(
  parameter int COLS = 32
) (
  input  logic [LFSR_W-1:0] state_i,
  output logic [COLS-1:0]   row_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] chain [COLS+1];

  assign chain[0] = state_i;

  for (genvar c = 0; c < COLS; c++) begin : g_step
    logic fb;
    assign fb           = chain[c][15] ^ chain[c][13] ^ chain[c][12] ^ chain[c][10];
    assign chain[c+1]   = {chain[c][LFSR_W-2:0], fb};
    assign row_o[c]     = fb;
  end

  assign next_o = chain[COLS];
endmodule

// File: rtl/life_row_calc.sv
// Next-generation value for one row, wrapping horizontally.
module life_row_calc #(
  parameter int COLS = 32
) (
  input  logic [COLS-1:0] up,
  input  logic [COLS-1:0] mid,
  input  logic [COLS-1:0] dn,
  output logic [COLS-1:0] nxt
);
  for (genvar c = 0; c < COLS; c++) begin : g_cell
    localparam int L = (c == 0) ? COLS - 1 : c - 1;
    localparam int R = (c == COLS - 1) ? 0 : c + 1;
    logic [3:0] n;
    assign n = 4'(up[L]) + 4'(up[c]) + 4'(up[R]) +
               4'(mid[L]) + 4'(mid[R]) +
               4'(dn[L]) + 4'(dn[c]) + 4'(dn[R]);
    assign nxt[c] = (n == 4'd3) | (mid[c] & (n == 4'd2));
  end
endmodule

// File: rtl/life_engine.sv
module life_engine
  import life_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int ROWS  = 24,
  parameter int DIV_W = 4,
  localparam int XW   = $clog2(COLS),
  localparam int YW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             hold,
  input  logic             step_req,
  input  logic             rand_req,
  input  logic             wr_en,
  input  logic [XW-1:0]    wr_x,
  input  logic [YW-1:0]    wr_y,
  input  logic             wr_val,
  input  logic [XW-1:0]    rd_x,
  input  logic [YW-1:0]    rd_y,
  output logic             rd_val
);
  localparam logic [YW-1:0] LAST_ROW = YW'(ROWS - 1);

  logic [ROWS-1:0][COLS-1:0] grid;
  logic [ROWS-1:0][COLS-1:0] shadow;
  eng_state_e                state;
  logic [YW-1:0]             row;
  logic [YW-1:0]             row_up;
  logic [YW-1:0]             row_dn;
  logic [LFSR_W-1:0]         lfsr;
  logic [LFSR_W-1:0]         lfsr_nxt;
  logic [COLS-1:0]           calc_row;
  logic [COLS-1:0]           fill_row;
  logic                      gen_req;
  logic                      gen_pend;
  logic                      fill_pend;
  logic                      rand_q;
  logic                      rand_rise;
  logic                      take_fill;
  logic                      take_gen;
  logic                      busy;
  logic                      ed_v;
  logic [XW-1:0]             ed_x;
  logic [YW-1:0]             ed_y;
  logic                      ed_val;

  life_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (frame_pulse),
    .hold        (hold),
    .step_req    (step_req),
    .rate_div    (rate_div),
    .gen_req     (gen_req)
  );

  assign row_up = (row == '0) ? LAST_ROW : row - 1'b1;
  assign row_dn = (row == LAST_ROW) ? '0 : row + 1'b1;

  life_row_calc #(.COLS(COLS)) u_calc (
    .up  (grid[row_up]),
    .mid (grid[row]),
    .dn  (grid[row_dn]),
    .nxt (calc_row)
  );

  life_lfsr_fill #(.COLS(COLS)) u_fill (
    .state_i (lfsr),
    .row_o   (fill_row),
    .next_o  (lfsr_nxt)
  );

  assign rand_rise = rand_req & ~rand_q;
  assign take_fill = (state == ST_IDLE) & fill_pend;
  assign take_gen  = (state == ST_IDLE) & ~fill_pend & gen_pend;
  assign busy      = (state == ST_CALC) | (state == ST_FILL);

  // request queue: one pending entry per kind
  always_ff @(posedge clk) begin
    if (rst) begin
      rand_q    <= 1'b0;
      fill_pend <= 1'b0;
      gen_pend  <= 1'b0;
    end else begin
      rand_q    <= rand_req;
      fill_pend <= (fill_pend & ~take_fill) | rand_rise;
      gen_pend  <= (gen_pend & ~take_gen) | gen_req;
    end
  end

  // parked editor write
  always_ff @(posedge clk) begin
    if (rst) begin
      ed_v   <= 1'b0;
      ed_x   <= '0;
      ed_y   <= '0;
      ed_val <= 1'b0;
    end else if (state == ST_COMMIT) begin
      ed_v <= 1'b0;
    end else if (busy && wr_en) begin
      ed_v   <= 1'b1;
      ed_x   <= wr_x;
      ed_y   <= wr_y;
      ed_val <= wr_val;
    end
  end

  // sequencer, shadow and visible field
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      row    <= '0;
      lfsr   <= LFSR_SEED;
      grid   <= '0;
      shadow <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wr_en)
            grid[wr_y][wr_x] <= wr_val;
          if (take_fill) begin
            state <= ST_FILL;
            row   <= '0;
          end else if (take_gen) begin
            state <= ST_CALC;
            row   <= '0;
          end
        end
        ST_CALC, ST_FILL: begin
          if (state == ST_FILL) begin
            shadow[row] <= fill_row;
            lfsr        <= lfsr_nxt;
          end else begin
            shadow[row] <= calc_row;
          end
          if (row == LAST_ROW)
            state <= ST_COMMIT;
          else
            row <= row + 1'b1;
        end
        ST_COMMIT: begin
          grid <= shadow;
          if (wr_en)
            grid[wr_y][wr_x] <= wr_val;
          else if (ed_v)
            grid[ed_y][ed_x] <= ed_val;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_val <= 1'b0;
    else     rd_val <= grid[rd_y][rd_x];
  end
endmodule

// File: rtl/life_engine_chk.sv
module life_engine_chk
  import life_pkg::*;
#(
  parameter int COLS = 32,
  parameter int ROWS = 24,
  localparam int YW  = $clog2(ROWS)
) (
  input logic                      clk,
  input logic                      rst,
  input eng_state_e                state,
  input logic [YW-1:0]             row,
  input logic [ROWS-1:0][COLS-1:0] grid,
  input logic [LFSR_W-1:0]         lfsr,
  input logic                      wr_en,
  input logic                      ed_v,
  input logic                      hold,
  input logic                      step_req,
  input logic                      gen_req
);
  AST_GRID_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CALC || state == ST_FILL) |=> $stable(grid)); // R4

  AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMMIT) |=> (state == ST_IDLE)); // R4

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (int'(row) < ROWS)); // R4

  AST_EDIT_PARKED: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CALC || state == ST_FILL) && wr_en) |=> ed_v); // R10

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0); // R8

  AST_HOLD_BLOCKS_PACING: assert property (@(posedge clk) disable iff (rst)
    (hold && !step_req) |-> !gen_req); // R6
endmodule

bind life_engine life_engine_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state    (state),
  .row      (row),
  .grid     (grid),
  .lfsr     (lfsr),
  .wr_en    (wr_en),
  .ed_v     (ed_v),
  .hold     (hold),
  .step_req (step_req),
  .gen_req  (gen_req)
);

// File: tb/life_engine_tb.sv
`timescale 1ns/1ps
module life_engine_tb;
  localparam int COLS = 32;
  localparam int ROWS = 24;
  localparam int XW   = $clog2(COLS);
  localparam int YW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst;
  logic          frame_pulse;
  logic [3:0]    rate_div;
  logic          hold, step_req, rand_req;
  logic          wr_en, wr_val;
  logic [XW-1:0] wr_x, rd_x;
  logic [YW-1:0] wr_y, rd_y;
  logic          rd_val;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  life_engine #(.COLS(COLS), .ROWS(ROWS), .DIV_W(4)) u_dut (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .rate_div(rate_div),
    .hold(hold), .step_req(step_req), .rand_req(rand_req),
    .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_val(wr_val),
    .rd_x(rd_x), .rd_y(rd_y), .rd_val(rd_val)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        mg [ROWS][COLS];
  bit        ms [ROWS][COLS];
  int        m_st, m_row, m_fc;
  bit        m_pg, m_pr, m_sq, m_rq, m_rd;
  bit        m_ev, m_eval;
  int        m_ex, m_ey;
  bit [15:0] m_l;
  bit        s_rise, r_rise, tick, greq, tk_f, tk_g, fb, was_fill;

  function automatic bit next_cell(int y, int x);
    int n = 0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (dy != 0 || dx != 0)
          n += int'(mg[(y + dy + ROWS) % ROWS][(x + dx + COLS) % COLS]);
    return (n == 3) || (mg[y][x] && n == 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mg[y, x]) begin mg[y][x] = 0; ms[y][x] = 0; end
      m_st = 0; m_row = 0; m_fc = 0; m_pg = 0; m_pr = 0; m_sq = 0; m_rq = 0;
      m_rd = 0; m_ev = 0; m_eval = 0; m_ex = 0; m_ey = 0; m_l = 16'hACE1;
    end else begin
      s_rise = step_req && !m_sq;
      r_rise = rand_req && !m_rq;
      tick   = frame_pulse && !hold && (m_fc >= int'(rate_div));
      greq   = tick || s_rise;
      tk_f   = (m_st == 0) && m_pr;
      tk_g   = (m_st == 0) && !m_pr && m_pg;
      m_rd   = mg[rd_y][rd_x];
      if (m_st == 0) begin
        if (wr_en) mg[wr_y][wr_x] = wr_val;
        if (tk_f) begin m_st = 2; m_row = 0; end
        else if (tk_g) begin m_st = 1; m_row = 0; end
      end else if (m_st == 1 || m_st == 2) begin
        was_fill = (m_st == 2);
        for (int c = 0; c < COLS; c++) begin
          if (was_fill) begin
            fb = m_l[15] ^ m_l[13] ^ m_l[12] ^ m_l[10];
            m_l = {m_l[14:0], fb};
            ms[m_row][c] = fb;
          end else begin
            ms[m_row][c] = next_cell(m_row, c);
          end
        end
        if (wr_en) begin m_ev = 1; m_ex = wr_x; m_ey = wr_y; m_eval = wr_val; end
        if (m_row == ROWS - 1) m_st = 3; else m_row++;
      end else begin
        mg = ms;
        if (wr_en) mg[wr_y][wr_x] = wr_val;
        else if (m_ev) mg[m_ey][m_ex] = m_eval;
        m_ev = 0;
        m_st = 0;
      end
      m_pr = (m_pr && !tk_f) || r_rise;
      m_pg = (m_pg && !tk_g) || greq;
      if (hold) m_fc = 0;
      else if (frame_pulse) m_fc = tick ? 0 : (m_fc + 1) % 16;
      m_sq = step_req;
      m_rq = rand_req;
    end
  end

  // per-cycle comparison of the read port against the model (R11)
  always @(negedge clk) begin
    if (!rst)
      chk(rd_val === m_rd, "R11", "per-cycle rd_val", int'(rd_val), int'(m_rd));
  end

  // ---------------- read address walker and tasks ----------------
  bit scan = 0;
  int wx = 0, wy = 0;
  always @(posedge clk) begin
    #2;
    if (!scan) begin
      wx = (wx + 1) % COLS;
      if (wx == 0) wy = (wy + 1) % ROWS;
      rd_x = XW'(wx);
      rd_y = YW'(wy);
    end
  end

  task automatic wr(input int x, input int y, input bit v);
    wr_en = 1; wr_x = XW'(x); wr_y = YW'(y); wr_val = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int x, input int y, output bit v);
    scan = 1; rd_x = XW'(x); rd_y = YW'(y);
    @(negedge clk);
    v = rd_val;
    scan = 0;
  endtask

  task automatic expect_cell(input int x, input int y, input bit e,
                             input string req, input string what);
    bit v;
    rd(x, y, v);
    chk(v == e, req, what, int'(v), int'(e));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame;
    frame_pulse = 1;
    @(negedge clk);
    frame_pulse = 0;
    idle(39);
  endtask

  task automatic scan_all(input string req);
    bit v;
    int live = 0;
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++) begin
        rd(x, y, v);
        live += int'(v);
        chk(v == mg[y][x], req, "field vs model", int'(v), int'(mg[y][x]));
      end
    chk(live > 0 && live < ROWS * COLS, req, "live count in range", live, ROWS * COLS / 2);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst = 1; frame_pulse = 0; rate_div = 0; hold = 1; step_req = 0; rand_req = 0;
    wr_en = 0; wr_x = 0; wr_y = 0; wr_val = 0; rd_x = 0; rd_y = 0;
    idle(4);
    rst = 0;
    idle(1);

    expect_cell(0, 0, 0, "R1", "reset cell (0,0)");
    expect_cell(11, 10, 0, "R1", "reset cell (11,10)");
    expect_cell(31, 23, 0, "R1", "reset cell (31,23)");

    // horizontal blinker in the middle and one wrapping across the corner
    wr(10, 10, 1); wr(11, 10, 1); wr(12, 10, 1);
    wr(31, 0, 1);  wr(0, 0, 1);   wr(1, 0, 1);
    expect_cell(11, 10, 1, "R9", "idle write visible");

    // step held high across many generation times (R7)
    step_req = 1;
    idle(8);
    expect_cell(11, 9, 0, "R4", "mid-computation read shows old field");
    idle(50);
    expect_cell(11, 9, 1, "R2", "birth above blinker centre");
    expect_cell(11, 11, 1, "R2", "birth below blinker centre");
    expect_cell(10, 10, 0, "R2", "blinker end dies");
    expect_cell(11, 10, 1, "R2", "centre survives with 2");
    expect_cell(0, 23, 1, "R3", "birth wraps to last row");
    expect_cell(0, 1, 1, "R3", "birth below corner blinker");
    expect_cell(31, 0, 0, "R3", "left end across the edge dies");
    idle(100);
    expect_cell(11, 9, 1, "R7", "held step gives only one generation");
    step_req = 0;
    idle(2);

    // edit during a generation (R10)
    step_req = 1;
    idle(6);
    wr(20, 20, 1);
    idle(40);
    expect_cell(20, 20, 1, "R10", "parked edit applied after commit");
    expect_cell(10, 10, 1, "R10", "generation still committed");
    step_req = 0;
    idle(2);

    // second step while busy is queued (R12)
    step_req = 1; idle(2); step_req = 0;
    idle(6);
    step_req = 1; idle(2); step_req = 0;
    idle(80);
    expect_cell(10, 10, 1, "R12", "two queued generations ran");
    expect_cell(20, 20, 0, "R12", "lone cell died");

    // hold blocks pacing (R6)
    rate_div = 0;
    repeat (4) frame();
    expect_cell(10, 10, 1, "R6", "no generation while held");

    // free run with divisor 1 (R5)
    hold = 0; rate_div = 1;
    frame();
    expect_cell(10, 10, 1, "R5", "first pulse of period does nothing");
    frame();
    expect_cell(10, 10, 0, "R5", "second pulse advances");
    hold = 1;
    idle(4);

    // random fill (R8)
    rand_req = 1; idle(2); rand_req = 0;
    idle(60);
    scan_all("R8");

    // fill and step requested together: fill first, then generation (R12)
    rand_req = 1; step_req = 1;
    idle(2);
    rand_req = 0; step_req = 0;
    idle(100);
    scan_all("R12");

    // one more generation over a random field (R2/R3)
    step_req = 1; idle(2); step_req = 0;
    idle(60);
    scan_all("R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule